// File: doc/BRIEF.md
# Host Shared-Memory Access Port

This block lets an external processor reach two storage spaces inside a serial-bus protocol controller: a word RAM that it shares with an internal protocol engine, and a small register file. The processor opens a cycle by pulling its select and its strobe low. The block samples both on the rising clock edge. It waits while the internal engine owns the RAM. It then grants the cycle by pulling an active-low grant output low. Completion is signalled by pulling an active-low done output low.

The space select and the direction input are followed live until the first falling clock edge after the grant, and are frozen from then on. The address is followed live until the first rising edge after the grant, and is latched from then on. A strap input sets which level of the direction input means read. Register accesses complete sooner than RAM accesses.

Read data sits on a 16-bit output with its own drive enable, so an external pad can tri-state the bus. The data is valid before done falls. The drive enable is removed when the strobe returns high. A write stores the processor's data in the cycle in which done asserts. A simple arbiter shares the RAM with the engine's request input.

Top module: `hostmem_port`

## Requirements
- R1: After reset, grant_n and done_n are 1, rd_oe is 0 and eng_gnt is 0.
- R2: grant_n falls at the first rising edge where sel_n and strobe_n are both sampled 0, eng_gnt is 0 and eng_req is 0. When eng_req and a host strobe arrive at the same edge, the engine is granted (eng_gnt becomes 1) and grant_n stays 1.
- R3: Once grant_n is 0, raising sel_n does not end the cycle. The first rising edge that samples strobe_n at 1 returns grant_n and done_n to 1 and rd_oe to 0.
- R4: space_ram and dir follow their inputs until the first falling edge after grant_n falls. Changes after that edge have no effect on the cycle.
- R5: addr follows its input until the first rising edge after grant_n falls. Changes after that edge have no effect on the cycle.
- R6: space_ram=1 selects the RAM, indexed by addr[RAM_AW-1:0] (RAM_AW at most 14, default 8). space_ram=0 selects the 32-word register file, indexed by addr[4:0]. The two spaces hold separate contents.
- R7: With dir_pol=1, dir=1 means read and dir=0 means write. With dir_pol=0, dir=0 means read and dir=1 means write.
- R8: done_n falls REG_WAIT (default 3) rising edges after grant_n falls for a register access, and RAM_WAIT (default 7) edges after it falls for a RAM access.
- R9: On a read, rd_oe is 1 and rd_data holds the addressed word from at least one rising edge before done_n falls until the cycle ends.
- R10: On a write, wr_data is stored into the selected word at the rising edge where done_n falls.
- R11: While eng_gnt is 1, no host cycle is granted. eng_gnt stays 1 while eng_req stays 1. An eng_req raised during a host cycle is granted only after that cycle ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low chip select |
| strobe_n | input | 1 | Active-low access strobe |
| space_ram | input | 1 | 1 = RAM, 0 = register file |
| dir | input | 1 | Direction; its read sense is set by dir_pol |
| dir_pol | input | 1 | Strap giving the level of dir that means read |
| addr | input | 16 | Word address |
| wr_data | input | 16 | Write data from the processor |
| rd_data | output | 16 | Read data |
| rd_oe | output | 1 | Drive enable for rd_data onto the shared bus |
| grant_n | output | 1 | Active-low cycle grant |
| done_n | output | 1 | Active-low access complete |
| eng_req | input | 1 | Internal engine requests the RAM |
| eng_gnt | output | 1 | Internal engine owns the RAM |

## Verification
The assertions assume that the processor holds strobe_n low until done_n falls. They also assume that the engine keeps eng_req high until it has seen eng_gnt. Under both assumptions a cycle cannot end in the middle of its count, and a request cannot vanish before it is served. The stimulus drives every input one nanosecond after a rising edge, so a value set there is captured at the next falling edge, and a value set three nanoseconds after the edge is not. The bench uses that timing to probe the transparent and latched windows of the control and address inputs, and it releases the strobe only after done_n has been observed low.

// File: rtl/hmp_pkg.sv
`timescale 1ns/1ps
package hmp_pkg;
  localparam int unsigned HMP_DW     = 16;
  localparam int unsigned HMP_AW     = 16;
  localparam int unsigned HMP_REG_AW = 5;

  typedef struct packed {
    logic to_ram;
    logic is_read;
  } hmp_kind_t;
endpackage

// File: rtl/hmp_latch.sv
`timescale 1ns/1ps
module hmp_latch
  import hmp_pkg::*;
#(
  parameter int unsigned LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grant_n,
  input  logic          space_ram,
  input  logic          dir,
  input  logic          dir_pol,
  input  logic [LW-1:0] addr,
  output hmp_kind_t     kind,
  output logic [LW-1:0] adr_eff
);
  logic          ctl_lk_q, ram_q, dir_q;
  logic          ctl_lk_d, ram_d, dir_d;
  logic          adr_lk_q, adr_lk_d;
  logic [LW-1:0] adr_q, adr_d;
  logic          ram_eff, dir_eff;

  // control hold: decided on the falling edge
  always_comb begin
    ctl_lk_d = !grant_n;
    ram_d    = ram_q;
    dir_d    = dir_q;
    if (!grant_n && !ctl_lk_q) begin
      ram_d = space_ram;
      dir_d = dir;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_lk_q <= 1'b0;
      ram_q    <= 1'b0;
      dir_q    <= 1'b0;
    end else begin
      ctl_lk_q <= ctl_lk_d;
      ram_q    <= ram_d;
      dir_q    <= dir_d;
    end
  end

  // address hold: decided on the rising edge
  always_comb begin
    adr_lk_d = !grant_n;
    adr_d    = adr_q;
    if (!grant_n && !adr_lk_q) adr_d = addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adr_lk_q <= 1'b0;
      adr_q    <= '0;
    end else begin
      adr_lk_q <= adr_lk_d;
      adr_q    <= adr_d;
    end
  end

  assign ram_eff      = ctl_lk_q ? ram_q : space_ram;
  assign dir_eff      = ctl_lk_q ? dir_q : dir;
  assign adr_eff      = adr_lk_q ? adr_q : addr;
  assign kind.to_ram  = ram_eff;
  assign kind.is_read = dir_pol ? dir_eff : !dir_eff;

  // R4: frozen control stays put for the rest of the cycle
  p_ctl_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_lk_q && $past(ctl_lk_q) |-> $stable(ram_eff) && $stable(dir_eff));

  // R5: latched address stays put for the rest of the cycle
  p_adr_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adr_lk_q && $past(adr_lk_q) && !grant_n |-> $stable(adr_eff));
endmodule

// File: rtl/hmp_seq.sv
`timescale 1ns/1ps
module hmp_seq
  import hmp_pkg::*;
#(
  parameter int unsigned REG_WAIT = 3,
  parameter int unsigned RAM_WAIT = 7
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sel_n,
  input  logic      strobe_n,
  input  logic      eng_req,
  input  hmp_kind_t kind,
  output logic      grant_n,
  output logic      done_n,
  output logic      eng_gnt,
  output logic      wr_fire,
  output logic      rd_load,
  output logic      cyc_end
);
  localparam int unsigned MAXW = (REG_WAIT > RAM_WAIT) ? REG_WAIT : RAM_WAIT;
  localparam int unsigned CW   = $clog2(MAXW + 1);

  logic          grant_q, grant_d, done_q, done_d, gnt_q, gnt_d;
  logic [CW-1:0] cnt_q, cnt_d, last_w;
  logic          active;

  assign last_w = kind.to_ram ? CW'(RAM_WAIT) : CW'(REG_WAIT);
  assign active = !grant_q;

  always_comb begin
    grant_d = grant_q;
    done_d  = done_q;
    gnt_d   = gnt_q;
    cnt_d   = cnt_q;
    wr_fire = 1'b0;
    rd_load = 1'b0;
    cyc_end = 1'b0;
    if (!active) begin
      if (gnt_q) begin
        gnt_d = eng_req;
      end else if (eng_req) begin
        gnt_d = 1'b1;
      end else if (!sel_n && !strobe_n) begin
        grant_d = 1'b0;
        cnt_d   = '0;
      end
    end else if (strobe_n) begin
      grant_d = 1'b1;
      done_d  = 1'b1;
      cnt_d   = '0;
      cyc_end = 1'b1;
    end else if (cnt_q != last_w) begin
      cnt_d = cnt_q + CW'(1);
      if (cnt_q == last_w - CW'(1)) begin
        done_d  = 1'b0;
        wr_fire = !kind.is_read;
      end
      if (cnt_q == last_w - CW'(2)) rd_load = kind.is_read;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b1;
      done_q  <= 1'b1;
      gnt_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      grant_q <= grant_d;
      done_q  <= done_d;
      gnt_q   <= gnt_d;
      cnt_q   <= cnt_d;
    end
  end

  assign grant_n = grant_q;
  assign done_n  = done_q;
  assign eng_gnt = gnt_q;

  // R3: strobe alone keeps a granted cycle open
  p_hold_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_n && !strobe_n |=> !grant_n);

  // R8: done only inside a granted cycle
  p_done_in_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_n |-> !grant_n);

  // R11: engine ownership blocks a host grant
  p_no_grant_engine_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eng_gnt && grant_n |=> grant_n);

  // R11: engine is never preempted
  p_no_preempt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eng_gnt && eng_req |=> eng_gnt);

  // R11: engine waits while the host cycle is open
  p_engine_waits_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_n && !strobe_n && !eng_gnt |=> !eng_gnt);
endmodule

// File: rtl/hmp_store.sv
`timescale 1ns/1ps
module hmp_store
  import hmp_pkg::*;
#(
  parameter int unsigned RAM_AW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_fire,
  input  logic                  rd_load,
  input  logic                  cyc_end,
  input  logic                  to_ram,
  input  logic [RAM_AW-1:0]     ram_idx,
  input  logic [HMP_REG_AW-1:0] reg_idx,
  input  logic [HMP_DW-1:0]     wdata,
  output logic [HMP_DW-1:0]     rdata,
  output logic                  rd_oe
);
  localparam int unsigned RAM_WORDS = 1 << RAM_AW;
  localparam int unsigned REG_WORDS = 1 << HMP_REG_AW;

  logic [HMP_DW-1:0] ram_mem [RAM_WORDS];
  logic [HMP_DW-1:0] reg_q   [REG_WORDS];
  logic [HMP_DW-1:0] rd_q, rd_mux;
  logic              oe_q, oe_d;

  always_ff @(posedge clk) begin
    if (wr_fire && to_ram) ram_mem[ram_idx] <= wdata;
  end

  for (genvar g = 0; g < REG_WORDS; g++) begin : g_reg
    logic hit;
    assign hit = wr_fire && !to_ram && (reg_idx == HMP_REG_AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   reg_q[g] <= '0;
      else if (hit) reg_q[g] <= wdata;
    end
  end

  assign rd_mux = to_ram ? ram_mem[ram_idx] : reg_q[reg_idx];

  always_comb begin
    oe_d = oe_q;
    if (cyc_end)      oe_d = 1'b0;
    else if (rd_load) oe_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q <= 1'b0;
      rd_q <= '0;
    end else begin
      oe_q <= oe_d;
      if (rd_load) rd_q <= rd_mux;
    end
  end

  assign rdata = rd_q;
  assign rd_oe = oe_q;

  // R9: data drive stays on until the cycle closes
  p_oe_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe && !cyc_end |=> rd_oe && $stable(rdata));
endmodule

// File: rtl/hostmem_port.sv
`timescale 1ns/1ps
module hostmem_port
  import hmp_pkg::*;
#(
  parameter int unsigned RAM_AW   = 8,
  parameter int unsigned REG_WAIT = 3,
  parameter int unsigned RAM_WAIT = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_n,
  input  logic        strobe_n,
  input  logic        space_ram,
  input  logic        dir,
  input  logic        dir_pol,
  input  logic [15:0] addr,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        rd_oe,
  output logic        grant_n,
  output logic        done_n,
  input  logic        eng_req,
  output logic        eng_gnt
);
  localparam int unsigned LW = (RAM_AW > HMP_REG_AW) ? RAM_AW : HMP_REG_AW;

  hmp_kind_t     kind;
  logic [LW-1:0] adr_eff;
  logic          wr_fire, rd_load, cyc_end;
  logic          unused_hi;

  assign unused_hi = ^addr[HMP_AW-1:LW];

  hmp_latch #(.LW(LW)) u_latch (
    .clk(clk), .rst_n(rst_n), .grant_n(grant_n), .space_ram(space_ram),
    .dir(dir), .dir_pol(dir_pol), .addr(addr[LW-1:0]),
    .kind(kind), .adr_eff(adr_eff)
  );

  hmp_seq #(.REG_WAIT(REG_WAIT), .RAM_WAIT(RAM_WAIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .strobe_n(strobe_n),
    .eng_req(eng_req), .kind(kind), .grant_n(grant_n), .done_n(done_n),
    .eng_gnt(eng_gnt), .wr_fire(wr_fire), .rd_load(rd_load), .cyc_end(cyc_end)
  );

  hmp_store #(.RAM_AW(RAM_AW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .rd_load(rd_load),
    .cyc_end(cyc_end), .to_ram(kind.to_ram),
    .ram_idx(adr_eff[RAM_AW-1:0]), .reg_idx(adr_eff[HMP_REG_AW-1:0]),
    .wdata(wr_data), .rdata(rd_data), .rd_oe(rd_oe)
  );

  // R9: read data is driven before done falls
  p_valid_before_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_n) && kind.is_read |-> $past(rd_oe) && rd_oe);

  // R3: a raised strobe closes the cycle at the next edge
  p_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_n && strobe_n |=> grant_n && done_n && !rd_oe);
endmodule

// File: tb/test_hostmem_port.sv
`timescale 1ns/1ps
module test_hostmem_port;
  logic        clk = 1'b0;
  logic        rst_n, sel_n, strobe_n, space_ram, dir, dir_pol, eng_req;
  logic [15:0] addr, wr_data, rd_data;
  logic        rd_oe, grant_n, done_n, eng_gnt;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  hostmem_port i_hostmem_port (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .strobe_n(strobe_n),
    .space_ram(space_ram), .dir(dir), .dir_pol(dir_pol), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_oe(rd_oe), .grant_n(grant_n),
    .done_n(done_n), .eng_req(eng_req), .eng_gnt(eng_gnt)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic go();
    @(posedge clk);
    #1;
  endtask

  task automatic start(input bit ram, input bit rd, input logic [15:0] a, input logic [15:0] wd);
    space_ram = ram;
    dir       = dir_pol ? rd : !rd;
    addr      = a;
    wr_data   = wd;
    sel_n     = 1'b0;
    strobe_n  = 1'b0;
  endtask

  task automatic wait_grant(output int w);
    w = 0;
    do begin go(); w++; end while (grant_n && w < 50);
  endtask

  task automatic wait_done(input int from, output int lat, output bit oe_prev, output logic [15:0] d_prev);
    lat = from; oe_prev = rd_oe; d_prev = rd_data;
    while (lat < 50) begin
      go(); lat++;
      if (!done_n) break;
      oe_prev = rd_oe; d_prev = rd_data;
    end
  endtask

  task automatic close_cycle(input string req);
    strobe_n = 1'b1; sel_n = 1'b1;
    go();
    check(req, "grant_n after strobe high", grant_n, 1);
    check(req, "done_n after strobe high", done_n, 1);
    check(req, "rd_oe after strobe high", rd_oe, 0);
  endtask

  task automatic access(input bit ram, input bit rd, input logic [15:0] a, input logic [15:0] wd,
                        output logic [15:0] rv, output int lat);
    int w; bit oep; logic [15:0] dp;
    start(ram, rd, a, wd);
    wait_grant(w);
    check("R2", "edges to grant", w, 1);
    wait_done(0, lat, oep, dp);
    rv = rd_data;
    if (rd) begin
      check("R9", "rd_oe before done", oep, 1);
      check("R9", "data before done", dp, rv);
    end
    close_cycle("R3");
  endtask

  task automatic t_reset();
    check("R1", "grant_n", grant_n, 1);
    check("R1", "done_n", done_n, 1);
    check("R1", "rd_oe", rd_oe, 0);
    check("R1", "eng_gnt", eng_gnt, 0);
  endtask

  task automatic t_reg_rw();
    logic [15:0] v; int lat;
    access(1'b0, 1'b0, 16'h0005, 16'hA5A5, v, lat);
    check("R8", "register write latency", lat, 3);
    access(1'b0, 1'b1, 16'h0005, 16'h0000, v, lat);
    check("R8", "register read latency", lat, 3);
    check("R10", "register readback", v, 16'hA5A5);
  endtask

  task automatic t_ram_rw();
    logic [15:0] v; int lat;
    access(1'b1, 1'b0, 16'h1234, 16'h0BEE, v, lat);
    check("R8", "RAM write latency", lat, 7);
    access(1'b1, 1'b1, 16'h1234, 16'h0000, v, lat);
    check("R8", "RAM read latency", lat, 7);
    check("R10", "RAM readback", v, 16'h0BEE);
    access(1'b1, 1'b1, 16'h0034, 16'h0000, v, lat);
    check("R6", "RAM index uses low address bits", v, 16'h0BEE);
  endtask

  task automatic t_space();
    logic [15:0] v; int lat;
    access(1'b1, 1'b0, 16'h0005, 16'h1111, v, lat);
    access(1'b0, 1'b1, 16'h0005, 16'h0000, v, lat);
    check("R6", "register 5 untouched by RAM write", v, 16'hA5A5);
    access(1'b1, 1'b1, 16'h0005, 16'h0000, v, lat);
    check("R6", "RAM word 5", v, 16'h1111);
    access(1'b0, 1'b1, 16'h0025, 16'h0000, v, lat);
    check("R6", "register index uses addr[4:0]", v, 16'hA5A5);
  endtask

  task automatic t_polarity();
    logic [15:0] v; int lat;
    dir_pol = 1'b0;
    access(1'b0, 1'b0, 16'h0006, 16'h6060, v, lat);
    access(1'b0, 1'b1, 16'h0006, 16'h0000, v, lat);
    check("R7", "low-sense read of written word", v, 16'h6060);
    dir_pol = 1'b1;
    access(1'b0, 1'b1, 16'h0006, 16'h0000, v, lat);
    check("R7", "high-sense read of same word", v, 16'h6060);
  endtask

  task automatic t_sel_release();
    int w, lat; bit oep; logic [15:0] dp;
    start(1'b0, 1'b1, 16'h0005, 16'h0000);
    wait_grant(w);
    sel_n = 1'b1;
    wait_done(0, lat, oep, dp);
    check("R3", "cycle survives sel_n high", lat, 3);
    check("R3", "data with sel_n high", rd_data, 16'hA5A5);
    close_cycle("R3");
  endtask

  task automatic t_engine_hold();
    int lat; bit oep; logic [15:0] dp;
    eng_req = 1'b1;
    go();
    check("R11", "engine granted", eng_gnt, 1);
    start(1'b0, 1'b1, 16'h0005, 16'h0000);
    for (int i = 0; i < 4; i++) begin
      go();
      check("R11", "no host grant while engine owns RAM", grant_n, 1);
      check("R11", "engine kept while requesting", eng_gnt, 1);
    end
    eng_req = 1'b0;
    go();
    check("R11", "engine released", eng_gnt, 0);
    check("R11", "host not yet granted", grant_n, 1);
    go();
    check("R2", "host granted after release", grant_n, 0);
    wait_done(0, lat, oep, dp);
    check("R11", "data after engine hold", rd_data, 16'hA5A5);
    close_cycle("R3");
  endtask

  task automatic t_engine_wait();
    int w, lat; bit oep; logic [15:0] dp;
    start(1'b0, 1'b1, 16'h0005, 16'h0000);
    wait_grant(w);
    eng_req = 1'b1;
    wait_done(0, lat, oep, dp);
    check("R11", "engine waits during host cycle", eng_gnt, 0);
    check("R11", "host cycle latency kept", lat, 3);
    close_cycle("R3");
    check("R11", "engine still waiting at close edge", eng_gnt, 0);
    go();
    check("R11", "engine granted after close", eng_gnt, 1);
    eng_req = 1'b0;
    go();
  endtask

  task automatic t_tie();
    int lat; bit oep; logic [15:0] dp;
    eng_req = 1'b1;
    start(1'b0, 1'b1, 16'h0005, 16'h0000);
    go();
    check("R2", "engine wins tie", eng_gnt, 1);
    check("R2", "host waits on tie", grant_n, 1);
    eng_req = 1'b0;
    go(); go();
    check("R2", "host granted after tie", grant_n, 0);
    wait_done(0, lat, oep, dp);
    close_cycle("R3");
  endtask

  task automatic t_addr_latch();
    logic [15:0] v; int w, lat; bit oep; logic [15:0] dp;
    access(1'b0, 1'b0, 16'h0007, 16'h7777, v, lat);
    access(1'b0, 1'b0, 16'h0009, 16'h9999, v, lat);
    access(1'b0, 1'b0, 16'h000B, 16'hBBBB, v, lat);
    start(1'b0, 1'b1, 16'h0007, 16'h0000);
    wait_grant(w);
    addr = 16'h0009;
    go();
    addr = 16'h000B;
    wait_done(1, lat, oep, dp);
    check("R5", "address taken at first edge after grant", rd_data, 16'h9999);
    check("R5", "latency with address change", lat, 3);
    close_cycle("R3");
  endtask

  task automatic t_ctl_latch();
    logic [15:0] v; int w, lat; bit oep; logic [15:0] dp;
    access(1'b1, 1'b0, 16'h0007, 16'h7070, v, lat);
    start(1'b1, 1'b1, 16'h0007, 16'h0000);
    wait_grant(w);
    space_ram = 1'b0;
    #2;
    space_ram = 1'b1;
    dir       = 1'b0;
    wr_data   = 16'hDEAD;
    wait_done(0, lat, oep, dp);
    check("R4", "space follows input until falling edge", lat, 3);
    check("R4", "register read despite late changes", rd_data, 16'h7777);
    check("R4", "still a read after late dir change", oep, 1);
    close_cycle("R3");
    access(1'b0, 1'b1, 16'h0007, 16'h0000, v, lat);
    check("R4", "register 7 not written", v, 16'h7777);
    access(1'b1, 1'b1, 16'h0007, 16'h0000, v, lat);
    check("R4", "RAM word 7 not written", v, 16'h7070);
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sel_n = 1'b1; strobe_n = 1'b1; space_ram = 1'b0; dir = 1'b1;
    dir_pol = 1'b1; eng_req = 1'b0; addr = '0; wr_data = '0;
    go(); go();
    t_reset();
    rst_n = 1'b1;
    go();
    t_reset();
    t_reg_rw();
    t_ram_rw();
    t_space();
    t_polarity();
    t_sel_release();
    t_engine_hold();
    t_engine_wait();
    t_tie();
    t_addr_latch();
    t_ctl_latch();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule